// File: doc/BRIEF.md
# Narrow Burst Word Packing Bridge

This bridge takes incrementing write bursts from an internal bus master and delivers them to a downstream port that only moves whole 32-bit words. Each burst is 4 or 8 beats long, and each beat carries a byte, a halfword or a full word. Narrow beats are gathered into complete words in little-endian lane order. The words then leave in order, with a word-aligned address that steps by four bytes per word and a word count that is fixed for the whole burst.

Bursts marked as wrapping are not supported as such. The bridge returns an error response on the final beat handshake of such a burst and sets a sticky status flag. It still moves the data exactly as it would for an incrementing burst from the same start address. The flag is cleared by writing 1 to it.

If the downstream port stalls, the bridge holds the pending word and stops taking beats. No data is dropped under backpressure.

Top module: `nbpack_bridge`

## Requirements
- R1: `req_ready` is high only while no burst is in progress. A request accepted on a `req_valid`/`req_ready` handshake drops `req_ready` on the next cycle, and `req_ready` stays low until the last beat of that burst has been accepted.
- R2: Size code 0 means byte beats, 1 means halfword beats, and 2 (or 3) means word beats. `req_long`=0 selects 4 beats and 1 selects 8. Every word of a burst carries `dn_count` = beats × bytes-per-beat / 4, which gives 1, 2, 2, 4, 4 and 8 words for byte/4, byte/8, half/4, half/8, word/4 and word/8. Exactly that many words are emitted.
- R3: Packing is little-endian. Byte beat k of a group fills bits [8k+7:8k] from `beat_data[7:0]`. Halfword beat k fills bits [16k+15:16k] from `beat_data[15:0]`. Word beats pass through unchanged. Unused upper bits of narrow beats are ignored.
- R4: The first word's `dn_addr` is the request address with bits [1:0] cleared, and each later word adds 4.
- R5: `dn_last` is high on the final word of a burst and low on every other word.
- R6: `beat_err` is high during the final beat handshake of a wrapping burst and low on every other beat handshake. A wrapping burst produces the same words, addresses and count as an incrementing one.
- R7: Accepting a wrapping request sets `stat_unsup` on the next cycle, and it stays set until a cycle with `stat_wr`=1 and `stat_wdata`=1. A write with `stat_wdata`=0 leaves it unchanged.
- R8: When a wrapping request is accepted in the same cycle as a clearing write, `stat_unsup` ends up set.
- R9: While `dn_valid` is high and `dn_ready` is low, `dn_valid`, `dn_data` and `dn_addr` hold their values. `beat_ready` is low whenever a word is waiting.
- R10: After reset, `req_ready`=1, `beat_ready`=0, `dn_valid`=0 and `stat_unsup`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Bridge idle, request can be taken |
| req_addr | input | 32 | Burst start byte address |
| req_size | input | 2 | Beat size code (0 byte, 1 half, 2/3 word) |
| req_long | input | 1 | 0: 4 beats, 1: 8 beats |
| req_wrap | input | 1 | Burst is marked as wrapping |
| beat_valid | input | 1 | Beat data present |
| beat_ready | output | 1 | Beat accepted this cycle if valid |
| beat_data | input | 32 | Beat data, narrow beats in low bits |
| beat_err | output | 1 | Error response for the current beat handshake |
| dn_valid | output | 1 | Packed word present downstream |
| dn_ready | input | 1 | Downstream accepts the word |
| dn_addr | output | 32 | Word-aligned address of the word |
| dn_data | output | 32 | Packed word |
| dn_count | output | 4 | Number of words in the current burst |
| dn_last | output | 1 | Final word of the burst |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 1 | Write 1 to clear the sticky flag |
| stat_unsup | output | 1 | Sticky unsupported-access flag |

## Verification
A lane index that drifts shows up on the next emitted word as bytes in the wrong positions or stale lanes. A beat counter that drifts shows up within one burst as a wrong count of words, a misplaced `dn_last`, or a `req_ready` that returns too early or too late. A corrupted wrap flag shows up as `beat_err` on the wrong beat of that burst. A wrong flag update shows up on `stat_unsup` one cycle after the request or clear. Random downstream stalls expose a lost or overwritten word as a mismatch on the very next compared word.

// File: rtl/nbpack_pkg.sv
package nbpack_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } beat_size_e;

  // Code 3 is folded onto word beats.
  function automatic beat_size_e norm_size(input logic [1:0] raw);
    case (raw)
      2'd0:    return SZ_BYTE;
      2'd1:    return SZ_HALF;
      default: return SZ_WORD;
    endcase
  endfunction

endpackage

// File: rtl/nbpack_ctrl.sv
module nbpack_ctrl
  import nbpack_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WORD_BYTES  = 4,
  parameter int SHORT_BEATS = 4,
  parameter int LONG_BEATS  = 8,
  localparam int CNT_W      = $clog2(LONG_BEATS + 1),
  localparam int IDX_W      = $clog2(WORD_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_long,
  input  logic              req_wrap,
  input  logic              beat_valid,
  output logic              beat_ready,
  output logic              beat_err,
  input  logic              out_full,
  output logic              start,
  output logic              beat_fire,
  output beat_size_e        size,
  output logic [IDX_W-1:0]  lane_idx,
  output logic              word_done,
  output logic [ADDR_W-1:0] word_addr,
  output logic [CNT_W-1:0]  word_count,
  output logic              word_last,
  output logic              wrap_seen
);

  localparam int SH = $clog2(WORD_BYTES);
  localparam int BYTES_W = CNT_W + SH + 1;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(WORD_BYTES - 1);
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(WORD_BYTES);

  logic              busy_q;
  logic              wrap_q;
  beat_size_e        size_q;
  logic [CNT_W-1:0]  left_q;
  logic [CNT_W-1:0]  count_q;
  logic [CNT_W-1:0]  wsent_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;

  beat_size_e        req_sz;
  logic [CNT_W-1:0]  req_beats;
  logic [BYTES_W-1:0] req_bytes;
  logic [CNT_W-1:0]  req_words;
  logic [IDX_W-1:0]  idx_last;

  always_comb begin
    req_sz    = norm_size(req_size);
    req_beats = req_long ? CNT_W'(LONG_BEATS) : CNT_W'(SHORT_BEATS);
    req_bytes = BYTES_W'(req_beats) << req_sz;
    req_words = CNT_W'(req_bytes >> SH);
    idx_last  = IDX_W'((WORD_BYTES >> size_q) - 1);
  end

  assign req_ready  = ~busy_q;
  assign start      = req_valid & req_ready;
  assign beat_ready = busy_q & ~out_full;
  assign beat_fire  = beat_valid & beat_ready;
  assign word_done  = beat_fire & (idx_q == idx_last);
  assign word_last  = (left_q == CNT_W'(1));
  assign beat_err   = busy_q & wrap_q & word_last;
  assign size       = size_q;
  assign lane_idx   = idx_q;
  assign word_addr  = addr_q;
  assign word_count = count_q;
  assign wrap_seen  = start & req_wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      wrap_q  <= 1'b0;
      size_q  <= SZ_WORD;
      left_q  <= '0;
      count_q <= '0;
      wsent_q <= '0;
      idx_q   <= '0;
      addr_q  <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      wrap_q  <= req_wrap;
      size_q  <= req_sz;
      left_q  <= req_beats;
      count_q <= req_words;
      wsent_q <= '0;
      idx_q   <= '0;
      addr_q  <= req_addr & ALIGN_MASK;
    end else if (beat_fire) begin
      left_q <= left_q - CNT_W'(1);
      if (word_last) busy_q <= 1'b0;
      if (word_done) begin
        idx_q   <= '0;
        addr_q  <= addr_q + ADDR_STEP;
        wsent_q <= wsent_q + CNT_W'(1);
      end else begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  // R2
  words_within_count_chk: assert property (@(posedge clk) disable iff (rst)
    word_done |-> (wsent_q < count_q));

  // R5
  last_word_index_chk: assert property (@(posedge clk) disable iff (rst)
    (word_done && word_last) |-> (wsent_q == count_q - CNT_W'(1)));

endmodule

// File: rtl/nbpack_lane_merge.sv
module nbpack_lane_merge
  import nbpack_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(WORD_BYTES),
  localparam int DATA_W    = 8 * WORD_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              beat_fire,
  input  beat_size_e        size,
  input  logic [IDX_W-1:0]  lane_idx,
  input  logic [DATA_W-1:0] beat_data,
  output logic [DATA_W-1:0] merged
);

  logic [DATA_W-1:0] acc_q;

  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
    logic       hit;
    logic [7:0] src;
    always_comb begin
      case (size)
        SZ_BYTE: begin
          hit = (lane_idx == IDX_W'(b));
          src = beat_data[7:0];
        end
        SZ_HALF: begin
          hit = (lane_idx == IDX_W'(b / 2));
          src = beat_data[8*(b%2) +: 8];
        end
        default: begin
          hit = 1'b1;
          src = beat_data[8*b +: 8];
        end
      endcase
    end
    assign merged[8*b +: 8] = hit ? src : acc_q[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst || start) acc_q <= '0;
    else if (beat_fire) acc_q <= merged;
  end

endmodule

// File: rtl/nbpack_out_reg.sv
module nbpack_out_reg #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] in_data,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [CNT_W-1:0]  in_count,
  input  logic              in_last,
  input  logic              dn_ready,
  output logic              dn_valid,
  output logic [DATA_W-1:0] dn_data,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [CNT_W-1:0]  dn_count,
  output logic              dn_last
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
      dn_addr  <= '0;
      dn_count <= '0;
      dn_last  <= 1'b0;
    end else if (load) begin
      dn_valid <= 1'b1;
      dn_data  <= in_data;
      dn_addr  <= in_addr;
      dn_count <= in_count;
      dn_last  <= in_last;
    end else if (dn_ready) begin
      dn_valid <= 1'b0;
    end
  end

  // R9
  held_word_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data) && $stable(dn_addr)));

  // R9
  no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> !dn_valid);

endmodule

// File: rtl/nbpack_status.sv
module nbpack_status (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr_wr,
  input  logic clr_data,
  output logic sticky
);

  always_ff @(posedge clk) begin
    if (rst) sticky <= 1'b0;
    else if (set) sticky <= 1'b1;
    else if (clr_wr && clr_data) sticky <= 1'b0;
  end

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set |=> sticky);

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sticky && !(clr_wr && clr_data)) |=> sticky);

endmodule

// File: rtl/nbpack_bridge.sv
module nbpack_bridge
  import nbpack_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WORD_BYTES  = 4,
  parameter int SHORT_BEATS = 4,
  parameter int LONG_BEATS  = 8,
  localparam int DATA_W     = 8 * WORD_BYTES,
  localparam int CNT_W      = $clog2(LONG_BEATS + 1),
  localparam int IDX_W      = $clog2(WORD_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_long,
  input  logic              req_wrap,
  input  logic              beat_valid,
  output logic              beat_ready,
  input  logic [DATA_W-1:0] beat_data,
  output logic              beat_err,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_data,
  output logic [CNT_W-1:0]  dn_count,
  output logic              dn_last,
  input  logic              stat_wr,
  input  logic              stat_wdata,
  output logic              stat_unsup
);

  logic              start;
  logic              beat_fire;
  beat_size_e        size;
  logic [IDX_W-1:0]  lane_idx;
  logic              word_done;
  logic [ADDR_W-1:0] word_addr;
  logic [CNT_W-1:0]  word_count;
  logic              word_last;
  logic              wrap_seen;
  logic [DATA_W-1:0] merged;

  nbpack_ctrl #(
    .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES),
    .SHORT_BEATS(SHORT_BEATS), .LONG_BEATS(LONG_BEATS)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_long(req_long), .req_wrap(req_wrap),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_err(beat_err),
    .out_full(dn_valid),
    .start(start), .beat_fire(beat_fire), .size(size), .lane_idx(lane_idx),
    .word_done(word_done), .word_addr(word_addr), .word_count(word_count),
    .word_last(word_last), .wrap_seen(wrap_seen)
  );

  nbpack_lane_merge #(.WORD_BYTES(WORD_BYTES)) u_merge (
    .clk(clk), .rst(rst), .start(start), .beat_fire(beat_fire),
    .size(size), .lane_idx(lane_idx), .beat_data(beat_data), .merged(merged)
  );

  nbpack_out_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_out (
    .clk(clk), .rst(rst), .load(word_done),
    .in_data(merged), .in_addr(word_addr), .in_count(word_count), .in_last(word_last),
    .dn_ready(dn_ready), .dn_valid(dn_valid), .dn_data(dn_data),
    .dn_addr(dn_addr), .dn_count(dn_count), .dn_last(dn_last)
  );

  nbpack_status u_status (
    .clk(clk), .rst(rst), .set(wrap_seen),
    .clr_wr(stat_wr), .clr_data(stat_wdata), .sticky(stat_unsup)
  );

endmodule

// File: tb/nbpack_bridge_bench.sv
module nbpack_bridge_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready, req_long, req_wrap;
  logic [31:0] req_addr;
  logic [1:0]  req_size;
  logic        beat_valid, beat_ready, beat_err;
  logic [31:0] beat_data;
  logic        dn_valid, dn_ready, dn_last;
  logic [31:0] dn_addr, dn_data;
  logic [3:0]  dn_count;
  logic        stat_wr, stat_wdata, stat_unsup;

  always #4 clk = ~clk;

  nbpack_bridge u_nbpack_bridge (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_long(req_long), .req_wrap(req_wrap),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_data(beat_data),
    .beat_err(beat_err),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_data(dn_data),
    .dn_count(dn_count), .dn_last(dn_last),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .stat_unsup(stat_unsup)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit stall_en = 0;

  logic [31:0] q_data[$];
  logic [31:0] q_addr[$];
  int          q_cnt[$];
  bit          q_last[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Words per burst from the shape rules (R2).
  function automatic int words_of(input int sz, input int nb);
    int bytes;
    bytes = (sz >= 2) ? 4 : (1 << sz);
    return nb * bytes / 4;
  endfunction

  // Little-endian packing model (R3).
  function automatic logic [31:0] pack_word(input int sz, input logic [31:0] d[8], input int w);
    logic [31:0] r;
    r = '0;
    if (sz == 0) begin
      for (int k = 0; k < 4; k++) r[8*k +: 8] = d[4*w+k][7:0];
    end else if (sz == 1) begin
      for (int k = 0; k < 2; k++) r[16*k +: 16] = d[2*w+k][15:0];
    end else begin
      r = d[w];
    end
    return r;
  endfunction

  // Downstream monitor with random backpressure.
  initial begin
    bit          prev_stall;
    logic [31:0] prev_data, prev_addr;
    prev_stall = 0;
    prev_data = '0;
    prev_addr = '0;
    dn_ready = 1'b0;
    @(negedge clk);
    while (rst) @(negedge clk);
    forever begin
      dn_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;
      #1;
      if (prev_stall) begin
        chk(dn_valid, "R9", "valid dropped while stalled", {31'b0, dn_valid}, 32'd1);
        chk(dn_data == prev_data, "R9", "data moved while stalled", dn_data, prev_data);
        chk(dn_addr == prev_addr, "R9", "addr moved while stalled", dn_addr, prev_addr);
      end
      if (dn_valid && dn_ready) begin
        if (q_data.size() == 0) begin
          chk(0, "R2", "unexpected extra word", dn_data, 32'd0);
        end else begin
          logic [31:0] ed, ea;
          int ec;
          bit el;
          ed = q_data.pop_front();
          ea = q_addr.pop_front();
          ec = q_cnt.pop_front();
          el = q_last.pop_front();
          chk(dn_data == ed, "R3", "packed word", dn_data, ed);
          chk(dn_addr == ea, "R4", "word address", dn_addr, ea);
          chk(int'(dn_count) == ec, "R2", "word count", {28'b0, dn_count}, ec);
          chk(dn_last == el, "R5", "last flag", {31'b0, dn_last}, {31'b0, el});
        end
      end
      prev_stall = dn_valid && !dn_ready;
      prev_data = dn_data;
      prev_addr = dn_addr;
      @(negedge clk);
    end
  end

  task automatic run_burst(input logic [31:0] addr, input int sz, input bit lng,
                           input bit wrap, input bit clr_same);
    logic [31:0] d[8];
    int nb, nw, bytes, i;
    nb = lng ? 8 : 4;
    nw = words_of(sz, nb);
    for (int k = 0; k < 8; k++) d[k] = $urandom;
    for (int w = 0; w < nw; w++) begin
      q_data.push_back(pack_word(sz, d, w));
      q_addr.push_back((addr & 32'hFFFF_FFFC) + 32'(4 * w));
      q_cnt.push_back(nw);
      q_last.push_back(w == nw - 1);
    end
    bytes = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr = addr;
    req_size = 2'(sz);
    req_long = lng;
    req_wrap = wrap;
    stat_wr = clr_same;
    stat_wdata = clr_same;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    req_valid = 1'b0;
    stat_wr = 1'b0;
    stat_wdata = 1'b0;
    #1;
    chk(!req_ready, "R1", "ready low during burst", {31'b0, req_ready}, 32'd0);
    if (wrap)
      chk(stat_unsup, (clr_same ? "R8" : "R7"), "sticky set by wrap",
          {31'b0, stat_unsup}, 32'd1);
    i = 0;
    while (i < nb) begin
      if (stall_en && ($urandom % 4) == 0) begin
        beat_valid = 1'b0;
      end else begin
        beat_valid = 1'b1;
        beat_data = d[i];
        #1;
        if (dn_valid)
          chk(!beat_ready, "R9", "beat taken while word waits", {31'b0, beat_ready}, 32'd0);
        if (beat_ready) begin
          chk(beat_err == (wrap && i == nb - 1), "R6", "error response",
              {31'b0, beat_err}, {31'b0, (wrap && i == nb - 1)});
          if (i == nb - 1) bytes = 1;
          i++;
        end
      end
      @(negedge clk);
    end
    beat_valid = 1'b0;
    #1;
    if (bytes == 1)
      chk(req_ready, "R1", "ready back after last beat", {31'b0, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(0, "R1", "watchdog expired", 32'd0, 32'd1);
      summary();
    end
  end

  initial begin
    void'($urandom(32'd5171));
    rst = 1'b1;
    req_valid = 1'b0;
    req_addr = '0;
    req_size = '0;
    req_long = 1'b0;
    req_wrap = 1'b0;
    beat_valid = 1'b0;
    beat_data = '0;
    stat_wr = 1'b0;
    stat_wdata = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    #1;
    // R10 reset state
    chk(req_ready, "R10", "req_ready after reset", {31'b0, req_ready}, 32'd1);
    chk(!beat_ready, "R10", "beat_ready after reset", {31'b0, beat_ready}, 32'd0);
    chk(!dn_valid, "R10", "dn_valid after reset", {31'b0, dn_valid}, 32'd0);
    chk(!stat_unsup, "R10", "stat_unsup after reset", {31'b0, stat_unsup}, 32'd0);

    // Directed shapes, no stalls (R2 table)
    run_burst(32'h0000_1003, 0, 0, 0, 0);
    run_burst(32'h0000_2000, 0, 1, 0, 0);
    run_burst(32'h0000_3002, 1, 0, 0, 0);
    run_burst(32'h0000_4000, 1, 1, 0, 0);
    run_burst(32'h0000_5001, 2, 0, 0, 0);
    run_burst(32'h0000_6000, 2, 1, 0, 0);
    run_burst(32'h0000_7000, 3, 0, 0, 0);
    chk(!stat_unsup, "R7", "no flag without wrap", {31'b0, stat_unsup}, 32'd0);

    // Wrap burst under backpressure (R6, R7)
    stall_en = 1;
    run_burst(32'hFFFF_FFF4, 1, 1, 1, 0);
    @(negedge clk);
    stat_wr = 1'b1;
    stat_wdata = 1'b0;
    @(negedge clk);
    stat_wr = 1'b0;
    #1;
    chk(stat_unsup, "R7", "write of zero ignored", {31'b0, stat_unsup}, 32'd1);
    @(negedge clk);
    stat_wr = 1'b1;
    stat_wdata = 1'b1;
    @(negedge clk);
    stat_wr = 1'b0;
    stat_wdata = 1'b0;
    #1;
    chk(!stat_unsup, "R7", "write of one clears", {31'b0, stat_unsup}, 32'd0);

    // Set and clear together (R8)
    run_burst(32'h0000_8000, 0, 1, 1, 1);

    // Random mix
    for (int n = 0; n < 60; n++) begin
      run_burst($urandom, int'($urandom % 4), 1'($urandom), (($urandom % 4) == 0), 0);
    end

    for (int t = 0; t < 2000 && q_data.size() != 0; t++) @(negedge clk);
    chk(q_data.size() == 0, "R2", "all expected words delivered", q_data.size(), 32'd0);
    summary();
  end

endmodule